// File: doc/BRIEF.md
# I2C Slave Word Receiver

This block is the receive side of an I2C target device. It watches the SCL and SDA lines, after synchronising them to the system clock, and waits for a START. After each START it collects the first byte as an address byte. It compares the upper seven bits of that byte with its own 7-bit address. Two bits of that address come from board-level strap pins and the other five come from a configuration input. If the address does not match, the block leaves SDA released on the acknowledge clock and sits out the rest of the transfer until the next START. If the address matches, the block pulls SDA low on the acknowledge clock. When the direction bit is 0, it then acknowledges every data byte that follows.

Data bytes arrive MSB first. They are acknowledged one at a time, but they are delivered to the host side as words of one, two or three bytes, chosen by a 2-bit length field. Only a complete word is written into a small first-word-fall-through receive queue. A STOP or a repeated START throws away a partly built word. A word that arrives while the queue is full is dropped and raises a sticky error flag. A host request output tells the bus side whether the queue can still accept a word.

Top module: `i2c_word_rx`

## Requirements
- R1: After reset, sda_pull, rx_not_empty and rx_overflow are 0, and host_req equals enable.
- R2: The own address is {addr_cfg[6:3], addr_pin_b, addr_cfg[1], addr_pin_a}, so addr_cfg bits 2 and 0 are ignored. An address byte whose bits [7:1] equal the own address is acknowledged by sda_pull=1 during the 9th SCL pulse.
- R3: A non-matching address byte gets no acknowledge on its 9th pulse. The data bytes of that transfer are neither acknowledged nor stored, and the next START is again recognised.
- R4: In a write session (address byte bit 0 = 0), every data byte is acknowledged on its 9th pulse. sda_pull changes only while SCL is low.
- R5: word_mode selects the word length: 00 = 1 byte, 01 = 2 bytes, 10 = 3 bytes, 11 = 1 byte. The first byte received is the most significant byte. The word is right-aligned in rd_data and the unused upper bits are 0.
- R6: The address byte is never counted as part of a word. Packing starts with the first data byte after the address byte.
- R7: A STOP or a repeated START discards a partly assembled word. Only complete words reach the queue.
- R8: After a matching address with bit 0 = 1, the address is acknowledged. No later byte of that transfer is acknowledged or stored.
- R9: rx_not_empty is 1 exactly while the queue holds a word. rd_data shows the oldest word, and rd_en removes it. rd_en on an empty queue has no effect.
- R10: A complete word that arrives while the queue is full is dropped and sets rx_overflow. rx_overflow then stays at 1 until reset. The bytes of that word are still acknowledged.
- R11: host_req is 1 when enable is 1 and the queue is not full, and 0 otherwise.
- R12: While enable is 0, the bus is ignored: nothing is acknowledged and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the bus engine on |
| addr_cfg | input | 7 | Own-address configuration (bits 2 and 0 unused) |
| addr_pin_a | input | 1 | Strap pin that sets own-address bit 0 |
| addr_pin_b | input | 1 | Strap pin that sets own-address bit 2 |
| word_mode | input | 2 | Bytes per word: 00=1, 01=2, 10=3, 11=1 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain drive) |
| rd_en | input | 1 | Remove the oldest word from the queue |
| rd_data | output | 24 | Oldest word in the queue, right-aligned |
| rx_not_empty | output | 1 | Queue holds at least one word |
| rx_overflow | output | 1 | Sticky flag: a word was dropped because the queue was full |
| host_req | output | 1 | Block enabled and queue able to take a word |

## Verification
Each word length is driven with a transfer that holds exactly one word, and each result shows that the first byte lands in the top position and the upper bits are zero. A two-byte mode fed with three bytes, and a one-byte partial word cut off by a repeated START, show the difference between keeping complete words and discarding fragments. The address tests change each strap pin against the configuration bits, and they use a read-direction byte, so that a missing acknowledge can be traced to either a wrong compare or the direction bit. A burst of five one-byte words into a four-entry queue separates the dropped word from the kept ones and exercises the sticky error flag.

// File: rtl/i2c_word_rx_pkg.sv
package i2c_word_rx_pkg;

  localparam int BYTE_W   = 8;
  localparam int WORD_MAX = 3;
  localparam int WORD_W   = BYTE_W * WORD_MAX;
  localparam int ADDR_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } bus_state_e;

  // word length field to byte count; reserved code falls back to one byte
  function automatic logic [1:0] bytes_per_word(input logic [1:0] mode);
    case (mode)
      2'd1:    return 2'd2;
      2'd2:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/i2c_word_rx_sync.sv
module i2c_word_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_level,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  always_comb begin
    sda_level = sda_s;
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_evt = scl_s & scl_d & sda_d & ~sda_s;
    stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2c_word_rx_engine.sv
module i2c_word_rx_engine
  import i2c_word_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_level,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              sda_pull,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_clear
);

  bus_state_e        state_q, state_n;
  logic [BYTE_W-1:0] shift_q, shift_n;
  logic [3:0]        bits_q, bits_n;
  logic              pull_q, pull_n;
  logic              step;

  assign step = ~enable | start_evt | stop_evt | scl_rise | scl_fall;

  always_comb begin
    state_n     = state_q;
    shift_n     = shift_q;
    bits_n      = bits_q;
    pull_n      = pull_q;
    byte_valid  = 1'b0;
    frame_clear = 1'b0;
    byte_data   = {shift_q[BYTE_W-2:0], sda_level};
    if (!enable || stop_evt) begin
      state_n = ST_IDLE; pull_n = 1'b0; bits_n = '0; frame_clear = 1'b1;
    end else if (start_evt) begin
      state_n = ST_ADDR; pull_n = 1'b0; bits_n = '0; frame_clear = 1'b1;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && bits_q != 4'd8) begin
            shift_n = {shift_q[BYTE_W-2:0], sda_level};
            bits_n  = bits_q + 4'd1;
            byte_valid = (state_q == ST_DATA) && (bits_q == 4'd7);
          end else if (scl_fall && bits_q == 4'd8) begin
            bits_n = '0;
            if (state_q == ST_DATA) begin
              pull_n = 1'b1; state_n = ST_DATA_ACK;
            end else if (shift_q[BYTE_W-1:1] == own_addr) begin
              pull_n = 1'b1; state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          pull_n  = 1'b0;
          state_n = shift_q[0] ? ST_SKIP : ST_DATA;
        end
        ST_DATA_ACK: if (scl_fall) begin
          pull_n  = 1'b0;
          state_n = ST_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      bits_q  <= '0;
      pull_q  <= 1'b0;
    end else if (step) begin
      state_q <= state_n;
      shift_q <= shift_n;
      bits_q  <= bits_n;
      pull_q  <= pull_n;
    end
  end

  assign sda_pull = pull_q;

endmodule

// File: rtl/i2c_word_rx_packer.sv
module i2c_word_rx_packer
  import i2c_word_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        word_mode,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_clear,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data
);

  logic [WORD_W-1:0] acc_q, acc_n, acc_shift, keep_mask;
  logic [1:0]        cnt_q, cnt_n, target;
  logic              load;

  assign load = byte_valid | frame_clear;

  always_comb begin
    target    = bytes_per_word(word_mode);
    acc_shift = {acc_q[WORD_W-BYTE_W-1:0], byte_data};
    keep_mask = {WORD_W{1'b1}} >> (WORD_W - int'(target) * BYTE_W);
    word_data = acc_shift & keep_mask;
    word_push = byte_valid && !frame_clear && (2'(cnt_q + 2'd1) == target);
    acc_n     = acc_shift;
    cnt_n     = cnt_q + 2'd1;
    if (frame_clear || word_push) begin
      acc_n = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/i2c_word_rx_fifo.sv
module i2c_word_rx_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full,
  output logic             overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [AW:0]      cnt_q, cnt_n;
  logic             do_wr, do_rd, ovf_n;

  always_comb begin
    full      = (cnt_q == CAP);
    not_empty = (cnt_q != '0);
    do_wr     = push & ~full;
    do_rd     = pop & not_empty;
    ovf_n     = overflow | (push & full);
    cnt_n     = cnt_q + (AW + 1)'(do_wr) - (AW + 1)'(do_rd);
    head      = mem[rd_q];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_rd) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_wr || do_rd) cnt_q <= cnt_n;
      overflow <= ovf_n;
    end
  end

endmodule

// File: rtl/i2c_word_rx.sv
module i2c_word_rx
  import i2c_word_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [6:0]        addr_cfg,
  input  logic              addr_pin_a,
  input  logic              addr_pin_b,
  input  logic [1:0]        word_mode,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic              rd_en,
  output logic [23:0]       rd_data,
  output logic              rx_not_empty,
  output logic              rx_overflow,
  output logic              host_req
);

  logic              rst_meta, rst_sync_n;
  logic              sda_level, scl_rise, scl_fall, start_evt, stop_evt;
  logic              byte_valid, frame_clear, word_push, fifo_full;
  logic [BYTE_W-1:0] byte_data;
  logic [WORD_W-1:0] word_data;
  logic [ADDR_W-1:0] own_addr;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign own_addr = {addr_cfg[6:3], addr_pin_b, addr_cfg[1], addr_pin_a};

  i2c_word_rx_sync u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_level(sda_level), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_word_rx_engine u_engine (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable), .own_addr(own_addr),
    .sda_level(sda_level), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_pull(sda_pull),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_clear(frame_clear)
  );

  i2c_word_rx_packer u_packer (
    .clk(clk), .rst_n(rst_sync_n), .word_mode(word_mode),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_clear(frame_clear),
    .word_push(word_push), .word_data(word_data)
  );

  i2c_word_rx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(word_push), .push_data(word_data),
    .pop(rd_en), .head(rd_data), .not_empty(rx_not_empty),
    .full(fifo_full), .overflow(rx_overflow)
  );

  assign host_req = enable & ~fifo_full;

endmodule

// File: rtl/i2c_word_rx_chk.sv
module i2c_word_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic sda_pull,
  input logic rx_not_empty,
  input logic rx_overflow,
  input logic host_req,
  input logic word_push,
  input logic fifo_full
);

  AST_NO_ACK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sda_pull); // R12
  AST_ACK_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in); // R4
  AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && enable) |-> !scl_in); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow); // R10
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_push && fifo_full) |=> rx_overflow); // R10
  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_push && !fifo_full) |=> rx_not_empty); // R9
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_not_empty); // R9
  AST_HREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !host_req); // R11

endmodule

bind i2c_word_rx i2c_word_rx_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .enable(enable), .scl_in(scl_in),
  .sda_pull(sda_pull), .rx_not_empty(rx_not_empty), .rx_overflow(rx_overflow),
  .host_req(host_req), .word_push(word_push), .fifo_full(fifo_full)
);

// File: tb/i2c_word_rx_test.sv
module i2c_word_rx_test;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [6:0]  addr_cfg = 7'b1010110;
  logic        addr_pin_a = 1'b1;
  logic        addr_pin_b = 1'b0;
  logic [1:0]  word_mode = 2'd0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        rd_en = 1'b0;
  logic        sda_pull, rx_not_empty, rx_overflow, host_req;
  logic [23:0] rd_data;
  logic        sda_line;
  logic        done = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_word_rx uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_cfg(addr_cfg),
    .addr_pin_a(addr_pin_a), .addr_pin_b(addr_pin_b), .word_mode(word_mode),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull), .rd_en(rd_en),
    .rd_data(rd_data), .rx_not_empty(rx_not_empty), .rx_overflow(rx_overflow),
    .host_req(host_req)
  );

  // mode, byte count, three bytes, expected word
  localparam logic [51:0] VEC [0:4] = '{
    {2'd0, 2'd1, 8'hA5, 8'h00, 8'h00, 24'h0000A5},
    {2'd1, 2'd2, 8'h12, 8'h34, 8'h00, 24'h001234},
    {2'd2, 2'd3, 8'hDE, 8'hAD, 8'hBE, 24'hDEADBE},
    {2'd3, 2'd1, 8'h3C, 8'h00, 8'h00, 24'h00003C},
    {2'd1, 2'd3, 8'h11, 8'h22, 8'h33, 24'h001122}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = sda_line;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic pop();
    rd_en = 1'b1; @(negedge clk);
    rd_en = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [1:0] nb;
    logic [7:0] bt;
    repeat (5) @(negedge clk);
    chk("R1 sda_pull", 32'(sda_pull), 0);
    chk("R1 rx_not_empty", 32'(rx_not_empty), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 rx_overflow", 32'(rx_overflow), 0);
    chk("R1 host_req", 32'(host_req), 1);

    // table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < 5; i++) begin
      word_mode = VEC[i][51:50];
      nb = VEC[i][49:48];
      bus_start();
      send_byte(8'hA6, ack);
      chk("R2 address ack", 32'(ack), 0);
      for (int k = 0; k < 3; k++) begin
        if (k < int'(nb)) begin
          bt = (k == 0) ? VEC[i][47:40] : (k == 1) ? VEC[i][39:32] : VEC[i][31:24];
          send_byte(bt, ack);
          chk("R4 data ack", 32'(ack), 0);
        end
      end
      bus_stop(); wq();
      chk("R6 word present", 32'(rx_not_empty), 1);
      chk("R5 word value", 32'(rd_data), 32'(VEC[i][23:0]));
      pop();
      chk("R7 no partial word", 32'(rx_not_empty), 0);
    end

    // R3 mismatching address, then recovery on next START
    word_mode = 2'd0;
    bus_start();
    send_byte(8'hA8, ack);
    chk("R3 no ack on mismatch", 32'(ack), 1);
    send_byte(8'h55, ack);
    chk("R3 data not acked", 32'(ack), 1);
    bus_stop(); wq();
    chk("R3 nothing stored", 32'(rx_not_empty), 0);
    bus_start();
    send_byte(8'hA6, ack);
    chk("R3 next start recognised", 32'(ack), 0);
    send_byte(8'h77, ack);
    bus_stop(); wq();
    chk("R3 stored after recovery", 32'(rd_data), 32'h77);
    pop();

    // R2 strap pin a changes address bit 0
    addr_pin_a = 1'b0;
    bus_start();
    send_byte(8'hA6, ack);
    chk("R2 old address rejected", 32'(ack), 1);
    bus_stop();
    bus_start();
    send_byte(8'hA4, ack);
    chk("R2 pin a address acked", 32'(ack), 0);
    send_byte(8'h5A, ack);
    bus_stop(); wq();
    chk("R2 pin a data", 32'(rd_data), 32'h5A);
    pop();
    addr_pin_a = 1'b1;
    // R2 strap pin b changes address bit 2
    addr_pin_b = 1'b1;
    bus_start();
    send_byte(8'hAE, ack);
    chk("R2 pin b address acked", 32'(ack), 0);
    bus_stop();
    addr_pin_b = 1'b0;

    // R8 read direction: address acked, nothing after
    bus_start();
    send_byte(8'hA7, ack);
    chk("R8 read address acked", 32'(ack), 0);
    send_byte(8'h99, ack);
    chk("R8 no data ack", 32'(ack), 1);
    bus_stop(); wq();
    chk("R8 nothing stored", 32'(rx_not_empty), 0);

    // R7 repeated start discards half-built word
    word_mode = 2'd1;
    bus_start();
    send_byte(8'hA6, ack);
    send_byte(8'hEE, ack);
    bus_rstart();
    send_byte(8'hA6, ack);
    send_byte(8'hC1, ack);
    send_byte(8'hC2, ack);
    bus_stop(); wq();
    chk("R7 fragment discarded", 32'(rd_data), 32'h00C1C2);
    pop();
    chk("R7 single word only", 32'(rx_not_empty), 0);

    // R10 R11 overflow with 4-entry queue
    word_mode = 2'd0;
    bus_start();
    send_byte(8'hA6, ack);
    for (int k = 1; k <= 5; k++) begin
      send_byte(8'(k), ack);
      chk("R10 byte acked while full", 32'(ack), 0);
    end
    bus_stop(); wq();
    chk("R11 host_req when full", 32'(host_req), 0);
    chk("R10 overflow set", 32'(rx_overflow), 1);
    for (int k = 1; k <= 4; k++) begin
      chk("R9 oldest first", 32'(rd_data), 32'(k));
      pop();
    end
    chk("R10 dropped word absent", 32'(rx_not_empty), 0);
    pop();
    chk("R9 pop on empty", 32'(rx_not_empty), 0);
    chk("R11 host_req after drain", 32'(host_req), 1);
    chk("R10 overflow sticky", 32'(rx_overflow), 1);

    // R12 disabled
    enable = 1'b0;
    @(negedge clk);
    chk("R11 host_req disabled", 32'(host_req), 0);
    bus_start();
    send_byte(8'hA6, ack);
    chk("R12 no ack when off", 32'(ack), 1);
    send_byte(8'h42, ack);
    bus_stop(); wq();
    enable = 1'b1;
    wq();
    chk("R12 nothing stored when off", 32'(rx_not_empty), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule